// File: doc/BRIEF.md
# Image Transfer and Processing Sequencer

This block sits between a byte-wide host port, a shared pixel RAM and an image processing engine. It controls one image pass in three phases. In the load phase, incoming pixels go into the lower half of the RAM. Next it accepts a command byte, starts the engine in the requested mode and hands the RAM port to the engine until the engine reports completion. In the readout phase, it streams the processed upper half of the RAM back to the host one byte per read request. After that it is ready for the next image.

The host enables are synchronous and active high, and the host may hold one high for several clocks. The block detects the rising edge of each enable, so every assertion counts as exactly one transfer, however long it lasts. The RAM has a single port. The block drives its address, write data and write strobe while it owns the port. When `ramOwnHost` is low, the port belongs to the engine.

Top module: `img_xfer_seq`

## Requirements
- R1: After reset the block is in the load phase with `ramAddr` = 0, `ramOwnHost` = 1, `ramWe` = 0 and `engStart` = 0.
- R2: In the load phase, each rising edge of `hostWrEn` writes `hostData` to the RAM at `ramAddr`, with `ramWe` high for exactly one cycle, and then advances `ramAddr` by one. An enable held for several cycles writes once.
- R3: Loading ends after PIXEL_COUNT writes. At that point `ramAddr` equals PIXEL_COUNT, and the next `hostWrEn` edge is taken as a command byte rather than a pixel.
- R4: A command whose bits [1:0] are 0 (binarize), 1 (2x2 halftone) or 2 (4x4 halftone) is accepted. On acceptance, `engMode` takes that value, `engStart` pulses high for one cycle and `ramOwnHost` drops to 0 while `engStart` is high.
- R5: A command with bits [1:0] = 3 is rejected. The block keeps waiting for a command, with no start pulse and no change of RAM ownership.
- R6: While the engine owns the RAM, host write and read enables are ignored: no RAM write, no address change, no second start. Processing ends only when `engDone` is high.
- R7: On `engDone`, `ramAddr` becomes PIXEL_COUNT (the first word of the upper half) and `ramOwnHost` returns to 1. `hostDout` always carries `ramRdData`, so the word at the current address is presented before the host samples it.
- R8: In the readout phase, each rising edge of `hostRdEn` advances `ramAddr` by one. An enable held for several cycles advances it once.
- R9: The PIXEL_COUNT-th read edge returns the block to the load phase with `ramAddr` = 0, and a new image can be loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| hostData | input | DATA_W | Pixel or command byte from the host |
| hostWrEn | input | 1 | Host write enable, active high, may be held |
| hostRdEn | input | 1 | Host read enable, active high, may be held |
| hostDout | output | DATA_W | Byte presented to the host during readout |
| ramAddr | output | ADDR_W | RAM address while the host side owns the port |
| ramWrData | output | DATA_W | RAM write data |
| ramWe | output | 1 | RAM write strobe, one cycle per accepted pixel |
| ramRdData | input | DATA_W | RAM read data (one-cycle synchronous read) |
| ramOwnHost | output | 1 | 1: sequencer drives the RAM port; 0: engine drives it |
| engStart | output | 1 | One-cycle start pulse to the engine |
| engMode | output | 2 | Processing type: 0 binarize, 1 2x2 halftone, 2 4x4 halftone |
| engDone | input | 1 | Engine completion pulse |

## Verification
The bench builds the block with PIXEL_COUNT = 16 and DATA_W = 8. This makes both address halves small enough to sweep every location in every pass, and lets each pass wrap back to load. Three complete images run, one in each valid mode, with enable hold lengths that cycle from one to three clocks. A behavioural engine transforms the lower half arithmetically, so the bench can compute every readout byte and the final RAM contents. A rejected command and enables issued while the engine works are inserted between passes.

// File: rtl/img_seq_pkg.sv
package img_seq_pkg;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_CMD  = 2'd1,
    PH_PROC = 2'd2,
    PH_READ = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAddr;
    logic setHigh;
    logic incAddr;
    logic latchMode;
  } dp_ctl_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic wrEdge;
    logic rdEdge;
    logic lastLoad;
    logic lastRead;
    logic cmdOk;
  } dp_stat_t;

endpackage

// File: rtl/img_seq_dp.sv
module img_seq_dp
  import img_seq_pkg::*;
#(
  parameter int PIXEL_COUNT = 4096,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [DATA_W-1:0] ramRdData,
  input  dp_ctl_t           ctl,
  output dp_stat_t          stat,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        engMode,
  output logic [DATA_W-1:0] hostDout
);

  localparam logic [ADDR_W-1:0] LOAD_LAST = ADDR_W'(PIXEL_COUNT - 1);
  localparam logic [ADDR_W-1:0] READ_LAST = ADDR_W'(2 * PIXEL_COUNT - 1);
  localparam logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(PIXEL_COUNT);

  logic wrPrev, rdPrev;
  logic [1:0] modeQ;

  // enable history: one transfer per assertion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= hostWrEn;
      rdPrev <= hostRdEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              addr <= '0;
    else if (ctl.clrAddr)   addr <= '0;
    else if (ctl.setHigh)   addr <= HIGH_BASE;
    else if (ctl.incAddr)   addr <= addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              modeQ <= 2'd0;
    else if (ctl.latchMode) modeQ <= hostData[1:0];
  end

  always_comb begin
    stat.wrEdge   = hostWrEn & ~wrPrev;
    stat.rdEdge   = hostRdEn & ~rdPrev;
    stat.lastLoad = (addr == LOAD_LAST);
    stat.lastRead = (addr == READ_LAST);
    stat.cmdOk    = (hostData[1:0] != 2'd3);
  end

  assign engMode  = modeQ;
  assign hostDout = ramRdData;

  // R8: a plain increment moves the address by exactly one
  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incAddr && !ctl.clrAddr && !ctl.setHigh) |=> addr == $past(addr) + 1'b1);

endmodule

// File: rtl/img_seq_ctl.sv
module img_seq_ctl
  import img_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dp_stat_t stat,
  input  logic     engDone,
  output dp_ctl_t  ctl,
  output logic     ramWe,
  output logic     engStart,
  output logic     ramOwnHost
);

  phase_t phase, phaseNext;
  logic   startQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_LOAD;
      startQ <= 1'b0;
    end else begin
      phase  <= phaseNext;
      startQ <= ctl.latchMode;
    end
  end

  always_comb begin
    phaseNext = phase;
    ctl       = '0;
    ramWe     = 1'b0;
    unique case (phase)
      PH_LOAD: if (stat.wrEdge) begin
        ramWe       = 1'b1;
        ctl.incAddr = 1'b1;
        if (stat.lastLoad) phaseNext = PH_CMD;
      end
      PH_CMD: if (stat.wrEdge && stat.cmdOk) begin
        ctl.latchMode = 1'b1;
        phaseNext     = PH_PROC;
      end
      PH_PROC: if (engDone) begin
        ctl.setHigh = 1'b1;
        phaseNext   = PH_READ;
      end
      PH_READ: if (stat.rdEdge) begin
        if (stat.lastRead) begin
          ctl.clrAddr = 1'b1;
          phaseNext   = PH_LOAD;
        end else begin
          ctl.incAddr = 1'b1;
        end
      end
      default: phaseNext = PH_LOAD;
    endcase
  end

  assign engStart   = startQ;
  assign ramOwnHost = (phase != PH_PROC);

  // R4: the start pulse is seen only once the engine holds the RAM
  assert_start_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> !ramOwnHost);

  // R5: a rejected command leaves the command phase in place
  assert_reject_stays_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CMD && stat.wrEdge && !stat.cmdOk) |=> phase == PH_CMD);

endmodule

// File: rtl/img_xfer_seq.sv
module img_xfer_seq
  import img_seq_pkg::*;
#(
  parameter int PIXEL_COUNT = 4096,
  parameter int DATA_W      = 8,
  localparam int ADDR_W     = $clog2(2 * PIXEL_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] hostDout,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              ramWe,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              ramOwnHost,
  output logic              engStart,
  output logic [1:0]        engMode,
  input  logic              engDone
);

  dp_ctl_t  ctl;
  dp_stat_t stat;

  img_seq_dp #(
    .PIXEL_COUNT(PIXEL_COUNT),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .hostData (hostData),
    .hostWrEn (hostWrEn),
    .hostRdEn (hostRdEn),
    .ramRdData(ramRdData),
    .ctl      (ctl),
    .stat     (stat),
    .addr     (ramAddr),
    .engMode  (engMode),
    .hostDout (hostDout)
  );

  img_seq_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .stat      (stat),
    .engDone   (engDone),
    .ctl       (ctl),
    .ramWe     (ramWe),
    .engStart  (engStart),
    .ramOwnHost(ramOwnHost)
  );

  assign ramWrData = hostData;

  // R2: one write strobe per enable assertion
  assert_we_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe);

  // R4: start is a single-cycle pulse
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R6: the host side never writes while the engine owns the RAM
  assert_no_write_proc_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ramOwnHost |-> !ramWe);

  // R6: the address is frozen until the engine finishes
  assert_proc_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ramOwnHost && !engDone) |=> $stable(ramAddr));

  // R7: readout starts at the first upper-half word with the host owning the RAM
  assert_read_base_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ramOwnHost && engDone) |=> (ramOwnHost && ramAddr == ADDR_W'(PIXEL_COUNT)));

endmodule

// File: tb/tb_img_xfer_seq.sv
module tb_img_xfer_seq;

  localparam int N  = 16;
  localparam int DW = 8;
  localparam int AW = $clog2(2 * N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] hostData = '0;
  logic          hostWrEn = 1'b0;
  logic          hostRdEn = 1'b0;
  logic [DW-1:0] hostDout;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWrData;
  logic          ramWe;
  logic [DW-1:0] ramRdData = '0;
  logic          ramOwnHost;
  logic          engStart;
  logic [1:0]    engMode;
  logic          engDone = 1'b0;

  int errors = 0;
  int checks = 0;
  int weCount = 0;
  int startCount = 0;
  int engBusy = 0;
  logic [1:0] engModeSeen = 2'd0;
  logic [DW-1:0] mem [2*N];

  always #5 clk = ~clk;

  img_xfer_seq #(.PIXEL_COUNT(N), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostDout(hostDout), .ramAddr(ramAddr),
    .ramWrData(ramWrData), .ramWe(ramWe), .ramRdData(ramRdData),
    .ramOwnHost(ramOwnHost), .engStart(engStart), .engMode(engMode),
    .engDone(engDone)
  );

  function automatic logic [DW-1:0] pix(input int pass, input int i);
    return DW'(i * 37 + pass * 11 + 5);
  endfunction

  function automatic logic [DW-1:0] proc(input logic [DW-1:0] p, input logic [1:0] m, input int i);
    logic [DW-1:0] key;
    key = DW'(8'h3C * (int'(m) + 1));
    return DW'((p ^ key) + DW'(i));
  endfunction

  // RAM model with one-cycle read and behavioural engine
  always @(posedge clk) begin
    if (ramWe) begin
      mem[ramAddr] <= ramWrData;
      weCount <= weCount + 1;
    end
    ramRdData <= mem[ramAddr];
    engDone <= 1'b0;
    if (engStart) begin
      startCount <= startCount + 1;
      engModeSeen <= engMode;
      engBusy <= 20;
    end else if (engBusy > 0) begin
      engBusy <= engBusy - 1;
      if (engBusy == 1) begin
        for (int j = 0; j < N; j++) mem[N + j] <= proc(mem[j], engModeSeen, j);
        engDone <= 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [DW-1:0] d, input int hold);
    @(negedge clk);
    hostData = d;
    hostWrEn = 1'b1;
    repeat (hold) @(negedge clk);
    hostWrEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hostRead(input int hold);
    @(negedge clk);
    hostRdEn = 1'b1;
    repeat (hold) @(negedge clk);
    hostRdEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int j = 0; j < 2 * N; j++) mem[j] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ramAddr == 0, "R1 addr", int'(ramAddr), 0);
    check(ramOwnHost == 1'b1 && ramWe == 1'b0 && engStart == 1'b0, "R1 outputs",
          {ramOwnHost, ramWe, engStart}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);

    for (int pass = 0; pass < 3; pass++) begin
      logic [1:0] m;
      int we0, st0;
      m = 2'(pass);
      we0 = weCount;
      // R2: load with enables held one to three cycles
      for (int i = 0; i < N; i++) begin
        hostWrite(pix(pass, i), (i % 3) + 1);
        if (i == 0) check(ramAddr == 1, "R2 addr step", int'(ramAddr), 1);
      end
      check(weCount - we0 == N, "R2 one write per enable", weCount - we0, N);
      for (int i = 0; i < N; i++)
        check(mem[i] == pix(pass, i), "R2 ram content", int'(mem[i]), int'(pix(pass, i)));
      // R3: load ends at N, owner still host
      check(ramAddr == AW'(N) && ramOwnHost, "R3 load end", int'(ramAddr), N);
      st0 = startCount;
      // R5: mode 3 rejected (on second pass)
      if (pass == 1) begin
        hostWrite(8'hA7, 2);
        repeat (3) @(negedge clk);
        check(startCount == st0 && ramOwnHost == 1'b1 && weCount - we0 == N,
              "R5 reject cmd 3", startCount - st0, 0);
      end
      // R4: command
      @(negedge clk);
      hostData = {6'b101010, m};
      hostWrEn = 1'b1;
      @(negedge clk);
      check(engStart == 1'b1 && ramOwnHost == 1'b0, "R4 start pulse",
            {engStart, ramOwnHost}, 2'b10);
      check(engMode == m, "R4 mode", int'(engMode), int'(m));
      @(negedge clk);
      check(engStart == 1'b0, "R4 start single", int'(engStart), 0);
      hostWrEn = 1'b0;
      // R6: enables during processing are ignored
      @(negedge clk);
      hostWrEn = 1'b1; hostRdEn = 1'b1; hostData = 8'hFF;
      @(negedge clk);
      hostWrEn = 1'b0; hostRdEn = 1'b0;
      @(negedge clk);
      hostWrEn = 1'b1;
      @(negedge clk);
      hostWrEn = 1'b0;
      check(ramAddr == AW'(N) && weCount - we0 == N && ramOwnHost == 1'b0,
            "R6 ignored in proc", int'(ramAddr), N);
      while (!engDone) @(negedge clk);
      check(startCount - st0 == 1, "R6 single start", startCount - st0, 1);
      repeat (2) @(negedge clk);
      // R7: readout base
      check(ramAddr == AW'(N) && ramOwnHost == 1'b1, "R7 read base", int'(ramAddr), N);
      // R8: readout sweep
      for (int i = 0; i < N; i++) begin
        logic [DW-1:0] e;
        e = proc(pix(pass, i), m, i);
        check(hostDout == e, "R7 R8 readout", int'(hostDout), int'(e));
        if (i < N - 1) begin
          hostRead((i % 3) + 1);
          check(ramAddr == AW'(N + i + 1), "R8 addr step", int'(ramAddr), N + i + 1);
        end else begin
          hostRead(2);
        end
      end
      // R9: back to load
      check(ramAddr == 0 && ramOwnHost == 1'b1, "R9 wrap to load", int'(ramAddr), 0);
    end
    finishRun();
  end

endmodule